// File: doc/BRIEF.md
# Port Safe-State Override Controller

This block sits between the normal output logic of a six-pin port bank and the pad drivers. When safe state is in force, it replaces each pin's output value, output enable and weak pull-up enable with a fail-safe condition. Each pin picks its own condition through a 2-bit code. The configuration comes in on plain input ports.

Safe state is in force while the software enable input is high, or while the qualified kill input is asserted. The kill input is asynchronous, so it always passes through a two-flop synchronizer first. After that it is used either at once or only after a two-cycle deglitch, as set by a mode input. The release path has no filter: once the synchronized kill drops, the override ends.

Top module: `port_safe_ctrl`

## Requirements
- R1: With sw_safe_en and kill_in low, and also after reset (where the synchronizer is cleared), the outputs equal the inputs: pin_out = func_out, pin_oe = func_oe, and every pin_pu bit = pu_en.
- R2: A pin whose code (ss_sel[2n+1:2n]) is 0 goes high impedance under safe state: pin_oe = 0 and pin_out = 0. Its pin_pu follows pu_en.
- R3: A pin with code 1 is driven high under safe state: pin_oe = 1 and pin_out = 1. Its pin_pu follows pu_en.
- R4: A pin with code 2 is driven low under safe state: pin_oe = 1 and pin_out = 0. Its pin_pu follows pu_en.
- R5: A pin with code 3 keeps func_out and func_oe under safe state, but its pin_pu is forced to 0.
- R6: sw_safe_en = 1 applies safe state in the same cycle, through a combinational path, to all pins according to their codes.
- R7: With kill_imm = 1, a kill_in level first sampled high at clock edge E0 takes effect just after edge E1, once it has passed the two synchronizer flops.
- R8: With kill_imm = 0, a kill_in pulse that is sampled high at only one edge never causes an override.
- R9: With kill_imm = 0, a kill_in pulse sampled high at edges E0 to E(L-1), with L >= 2, gives an override from just after E2 through just before E(L+1).
- R10: In both modes, the override ends just after edge E(L+1), where E(L) is the first edge that samples kill_in low. No release filter applies.
- R11: Safe state is the OR of sw_safe_en and the qualified kill. If the kill releases while sw_safe_en stays high, the override continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kill_in | input | 1 | Asynchronous external kill request |
| kill_imm | input | 1 | 1 = immediate kill, 0 = two-cycle deglitch |
| sw_safe_en | input | 1 | Software safe-state command |
| ss_sel | input | 12 | Per-pin safe-state codes, pin n at [2n+1:2n] |
| func_out | input | 6 | Normal per-pin output value |
| func_oe | input | 6 | Normal per-pin output enable |
| pu_en | input | 1 | Bank weak pull-up enable |
| pin_out | output | 6 | Final per-pin output value |
| pin_oe | output | 6 | Final per-pin output enable |
| pin_pu | output | 6 | Final per-pin pull-up enable |

## Verification
The software command and the kill path can both be active in the same cycle. The case that matters is a kill release, or a rejected glitch, that happens while the software enable is held high. The bench runs the same kill pulse sequences in both modes twice: once with the software enable low and once with it high. Every cycle it compares all three output vectors with a value computed arithmetically from the pulse length, the edge index and the OR rule. This confirms that dropping the kill never clears an override that software still commands.

// File: rtl/port_safe_pkg.sv
package port_safe_pkg;

    localparam int unsigned SS_CODE_W = 2;

    typedef enum logic [SS_CODE_W-1:0] {
        SS_HIZ  = 2'd0,
        SS_HIGH = 2'd1,
        SS_LOW  = 2'd2,
        SS_KEEP = 2'd3
    } ss_code_e;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
    } pin_drive_t;

endpackage

// File: rtl/ss_kill_qualifier.sv
module ss_kill_qualifier #(
    parameter int unsigned SYNC_STAGES     = 2,
    parameter int unsigned DEGLITCH_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill_async,
    input  logic immediate,
    output logic kill_valid
);

    localparam int unsigned HIST_W = (DEGLITCH_CYCLES > 1) ? DEGLITCH_CYCLES - 1 : 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [HIST_W-1:0]      hist;
    } kq_state_t;

    kq_state_t st_d, st_q;
    logic      kill_synced;
    logic      kill_filtered;

    assign kill_synced = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = kill_async;
        for (int i = 1; i < int'(SYNC_STAGES); i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.hist[0] = kill_synced;
        for (int i = 1; i < int'(HIST_W); i++) begin
            st_d.hist[i] = st_q.hist[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (DEGLITCH_CYCLES > 1) begin : g_filter
            assign kill_filtered = kill_synced & (&st_q.hist);
        end else begin : g_nofilter
            logic unused_hist;
            assign unused_hist   = ^st_q.hist;
            assign kill_filtered = kill_synced;
        end
    endgenerate

    assign kill_valid = immediate ? kill_synced : kill_filtered;

endmodule

// File: rtl/ss_pin_override.sv
module ss_pin_override
    import port_safe_pkg::*;
(
    input  logic                 safe_active,
    input  logic [SS_CODE_W-1:0] code,
    input  logic                 func_out,
    input  logic                 func_oe,
    input  logic                 pu_en,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 pin_pu
);

    pin_drive_t drv;

    always_comb begin
        drv.out = func_out;
        drv.oe  = func_oe;
        drv.pu  = pu_en;
        if (safe_active) begin
            unique case (ss_code_e'(code))
                SS_HIZ: begin
                    drv.out = 1'b0;
                    drv.oe  = 1'b0;
                end
                SS_HIGH: begin
                    drv.out = 1'b1;
                    drv.oe  = 1'b1;
                end
                SS_LOW: begin
                    drv.out = 1'b0;
                    drv.oe  = 1'b1;
                end
                SS_KEEP: begin
                    drv.pu  = 1'b0;
                end
                default: begin
                    drv.pu  = 1'b0;
                end
            endcase
        end
    end

    assign pin_out = drv.out;
    assign pin_oe  = drv.oe;
    assign pin_pu  = drv.pu;

endmodule

// File: rtl/port_safe_ctrl.sv
module port_safe_ctrl
    import port_safe_pkg::*;
#(
    parameter int unsigned NPINS           = 6,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter int unsigned DEGLITCH_CYCLES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       kill_in,
    input  logic                       kill_imm,
    input  logic                       sw_safe_en,
    input  logic [NPINS*SS_CODE_W-1:0] ss_sel,
    input  logic [NPINS-1:0]           func_out,
    input  logic [NPINS-1:0]           func_oe,
    input  logic                       pu_en,
    output logic [NPINS-1:0]           pin_out,
    output logic [NPINS-1:0]           pin_oe,
    output logic [NPINS-1:0]           pin_pu
);

    logic kill_valid;
    logic safe_active;

    ss_kill_qualifier #(
        .SYNC_STAGES    (SYNC_STAGES),
        .DEGLITCH_CYCLES(DEGLITCH_CYCLES)
    ) u_kill (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill_async(kill_in),
        .immediate (kill_imm),
        .kill_valid(kill_valid)
    );

    assign safe_active = sw_safe_en | kill_valid;

    generate
        for (genvar p = 0; p < int'(NPINS); p++) begin : g_pin
            ss_pin_override u_ovr (
                .safe_active(safe_active),
                .code       (ss_sel[p*SS_CODE_W +: SS_CODE_W]),
                .func_out   (func_out[p]),
                .func_oe    (func_oe[p]),
                .pu_en      (pu_en),
                .pin_out    (pin_out[p]),
                .pin_oe     (pin_oe[p]),
                .pin_pu     (pin_pu[p])
            );
        end
    endgenerate

endmodule

// File: rtl/port_safe_ctrl_chk.sv
module port_safe_ctrl_chk #(
    parameter int unsigned NPINS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 kill_in,
    input logic                 kill_imm,
    input logic                 sw_safe_en,
    input logic [NPINS*2-1:0]   ss_sel,
    input logic [NPINS-1:0]     func_out,
    input logic [NPINS-1:0]     func_oe,
    input logic                 pu_en,
    input logic [NPINS-1:0]     pin_out,
    input logic [NPINS-1:0]     pin_oe,
    input logic [NPINS-1:0]     pin_pu,
    input logic                 safe_active
);

    generate
        for (genvar p = 0; p < int'(NPINS); p++) begin : g_pc
            assert_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (safe_active && ss_sel[2*p +: 2] == 2'd0) |-> (!pin_oe[p] && pin_pu[p] == pu_en));
            assert_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (safe_active && ss_sel[2*p +: 2] == 2'd1) |-> (pin_oe[p] && pin_out[p]));
            assert_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (safe_active && ss_sel[2*p +: 2] == 2'd2) |-> (pin_oe[p] && !pin_out[p]));
            assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (safe_active && ss_sel[2*p +: 2] == 2'd3) |->
                (pin_out[p] == func_out[p] && pin_oe[p] == func_oe[p] && !pin_pu[p]));
            assert_sw_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (sw_safe_en && ss_sel[2*p +: 2] == 2'd1) |-> (pin_oe[p] && pin_out[p]));
            assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
                !safe_active |-> (pin_out[p] == func_out[p] && pin_oe[p] == func_oe[p] && pin_pu[p] == pu_en));
        end
    endgenerate

    assert_imm_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_active && !sw_safe_en && kill_imm) |-> $past(kill_in, 2));

    assert_deglitch_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_active && !sw_safe_en && !kill_imm) |-> ($past(kill_in, 2) && $past(kill_in, 3)));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_safe_en && !$past(kill_in, 2)) |-> !safe_active);

    assert_sw_forces_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_safe_en |-> safe_active);

endmodule

bind port_safe_ctrl port_safe_ctrl_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/port_safe_ctrl_test.sv
module port_safe_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kill_in = 1'b0;
    logic          kill_imm = 1'b0;
    logic          sw_safe_en = 1'b0;
    logic [2*NP-1:0] ss_sel = '0;
    logic [NP-1:0] func_out = '0;
    logic [NP-1:0] func_oe = '0;
    logic          pu_en = 1'b0;
    logic [NP-1:0] pin_out, pin_oe, pin_pu;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_safe_ctrl uut (
        .clk(clk), .rst_n(rst_n), .kill_in(kill_in), .kill_imm(kill_imm),
        .sw_safe_en(sw_safe_en), .ss_sel(ss_sel), .func_out(func_out),
        .func_oe(func_oe), .pu_en(pu_en), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pu(pin_pu)
    );

    task automatic check_all(input bit safe, input string tag);
        logic [NP-1:0] eo, ee, ep;
        for (int p = 0; p < NP; p++) begin
            int c;
            c = int'(ss_sel[2*p +: 2]);
            eo[p] = func_out[p];
            ee[p] = func_oe[p];
            ep[p] = pu_en;
            if (safe) begin
                if (c == 0) begin eo[p] = 1'b0; ee[p] = 1'b0; end
                else if (c == 1) begin eo[p] = 1'b1; ee[p] = 1'b1; end
                else if (c == 2) begin eo[p] = 1'b0; ee[p] = 1'b1; end
                else ep[p] = 1'b0;
            end
        end
        tests++;
        if (pin_out !== eo || pin_oe !== ee || pin_pu !== ep) begin
            fails++;
            $display("FAIL %s: out/oe/pu actual %b/%b/%b expected %b/%b/%b",
                     tag, pin_out, pin_oe, pin_pu, eo, ee, ep);
        end
    endtask

    function automatic logic [2*NP-1:0] rotated(input int base);
        logic [2*NP-1:0] v;
        for (int p = 0; p < NP; p++) v[2*p +: 2] = 2'((base + p) % 4);
        return v;
    endfunction

    task automatic idle(input int n);
        kill_in = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Kill pulse sampled high at edges E0..E(len-1); check after each edge.
    task automatic run_kill(input int len, input bit imm, input bit sw);
        idle(4);
        kill_imm   = imm;
        sw_safe_en = sw;
        ss_sel     = rotated(len);
        func_out   = 6'b011010;
        func_oe    = 6'b100110;
        pu_en      = 1'b1;
        kill_in    = 1'b1;
        for (int j = 0; j < len + 4; j++) begin
            bit act;
            string tag;
            @(posedge clk);
            @(negedge clk);
            kill_in = (j + 1 < len);
            #1;
            act = imm ? (j >= 1 && j <= len) : (j >= 2 && j <= len);
            act = act | sw;
            if (sw) tag = "R11 sw with kill";
            else if (j > len) tag = "R10 release";
            else if (imm) tag = "R7 immediate kill";
            else if (len == 1) tag = "R8 single-cycle glitch";
            else tag = "R9 deglitched kill";
            check_all(act, tag);
        end
        sw_safe_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        func_out = 6'b101010;
        func_oe  = 6'b110011;
        pu_en    = 1'b1;
        kill_in  = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check_all(1'b0, "R1 during reset");
        rst_n = 1'b1;
        kill_in = 1'b0;
        @(negedge clk); #1;
        check_all(1'b0, "R1 after reset");

        // Software enable sweep: every code on every pin
        for (int c = 0; c < 4; c++) begin
            for (int pat = 0; pat < 2; pat++) begin
                for (int f = 0; f < 2; f++) begin
                    string tag;
                    ss_sel   = (pat == 0) ? {NP{2'(c)}} : rotated(c);
                    func_out = f ? 6'b110100 : 6'b001011;
                    func_oe  = f ? 6'b011101 : 6'b100010;
                    pu_en    = f[0];
                    sw_safe_en = 1'b0;
                    #1;
                    check_all(1'b0, "R1 passthrough");
                    sw_safe_en = 1'b1;
                    #1;
                    case (c)
                        0: tag = "R2 R6 hiz code";
                        1: tag = "R3 R6 high code";
                        2: tag = "R4 R6 low code";
                        default: tag = "R5 R6 keep code";
                    endcase
                    check_all(1'b1, tag);
                    @(negedge clk); #1;
                    check_all(1'b1, tag);
                end
            end
        end
        sw_safe_en = 1'b0;

        // Kill paths: both modes, several pulse lengths, with and without software
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 2; s++) begin
                run_kill(1, bit'(m), bit'(s));
                run_kill(2, bit'(m), bit'(s));
                run_kill(3, bit'(m), bit'(s));
                run_kill(6, bit'(m), bit'(s));
            end
        end

        idle(4);
        #1;
        check_all(1'b0, "R10 quiet after kill tests");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule